// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Read-Modify-Write

This block is a parameterised general-purpose I/O port. Each pin has one output latch bit. A latch bit at 0 drives its pin low. A latch bit at 1 releases the pin, so the pin can then serve as an input. An external source sets the level of a released pin. In the pull-up variant a released pin shows a weak high. In the open-drain variant a released pin is not driven at all.

The core side offers four kinds of operation:
- a whole-byte write;
- single-bit operations, selected by a bit index;
- read-modify-write arithmetic on the latch;
- two read paths.

The read-pin path returns the external level after a two-flop synchroniser. The read-latch path returns the stored latch contents, whatever the pins show. Read-modify-write operations always take the latch as their source, never the pins.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1, every pin is released (`pin_oe` = 0, `pin_out` = all ones in the pull-up variant), and `rd_pin_data` reads all ones.
- R2: A byte write (`wr_byte_en`) stores `wr_byte_data` into the latch, visible on `rd_latch_data` after the next rising clock edge.
- R3: A bit operation changes only the bit selected by `bit_idx` (bit 0 is the LSB). The `bit_op` codes are: 0 sets the bit, 1 clears it, 2 copies `bit_val` into it, and 3 changes nothing.
- R4: When operations arrive in the same cycle, a byte write wins over a bit operation and over a read-modify-write. A bit operation wins over a read-modify-write.
- R5: A read-modify-write replaces the latch with latch OP `rmw_operand`. The `rmw_op` codes are: 0 AND, 1 OR, 2 XOR, 3 increment (wrapping FFh to 00h), and 4 decrement (wrapping 00h to FFh). Codes 5 to 7 leave the latch unchanged.
- R6: A read-modify-write takes the latch as its source and ignores the pin level.
- R7: `rd_pin_data` shows `pin_in` two rising edges after the pin changes, whatever the latch holds.
- R8: `rd_latch_data` shows the latch whatever the pin level is.
- R9: A latch bit at 0 gives `pin_oe` = 1 and `pin_out` = 0 for that pin. A latch bit at 1 gives `pin_oe` = 0, with `pin_out` = 1 in the pull-up variant and 0 in the open-drain variant.
- R10: XOR with FFh on a latch holding 55h gives AAh, and a second XOR with FFh gives 55h again.
- R11: In a cycle with no operation the latch holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_byte_en | input | 1 | Byte write strobe |
| wr_byte_data | input | 8 | Byte write data |
| bit_en | input | 1 | Bit operation strobe |
| bit_op | input | 2 | Bit operation code |
| bit_idx | input | 3 | Selected bit |
| bit_val | input | 1 | Value for the copy operation |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 3 | Read-modify-write operation code |
| rmw_operand | input | 8 | Read-modify-write operand |
| rd_pin_data | output | 8 | Synchronised pin level |
| rd_latch_data | output | 8 | Latch contents |
| pin_in | input | 8 | External pin level |
| pin_out | output | 8 | Pin output level |
| pin_oe | output | 8 | Pin drive enable |

## Verification
The bench applies conflicting strobes in one cycle. A design with the priority order reversed would keep the bit-operation or arithmetic result instead of the written byte. It holds the pins opposite to the latch during a read-modify-write. A design that took its source from the pins would store the pin level in the latch. Increment from FFh and decrement from 00h probe the wrap, which a width slip would break. The bench also samples the pin path one edge early and again on time, which catches a synchroniser that is too short or too long.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
   typedef enum logic [1:0] {
      BIT_SET = 2'd0,
      BIT_CLR = 2'd1,
      BIT_CPY = 2'd2,
      BIT_NOP = 2'd3
   } bit_op_e;

   typedef enum logic [2:0] {
      RMW_AND = 3'd0,
      RMW_OR  = 3'd1,
      RMW_XOR = 3'd2,
      RMW_INC = 3'd3,
      RMW_DEC = 3'd4
   } rmw_op_e;
endpackage

// File: rtl/qbio_rmw_alu.sv
module qbio_rmw_alu #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] operand,
   input  logic [2:0]       op,
   output logic [WIDTH-1:0] result,
   output logic             op_valid
);
   import qbio_pkg::*;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      result   = src;
      op_valid = 1'b1;
      case (op)
         RMW_AND: result = src & operand;
         RMW_OR:  result = src | operand;
         RMW_XOR: result = src ^ operand;
         RMW_INC: result = src + ONE;
         RMW_DEC: result = src - ONE;
         default: op_valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/qbio_latch.sv
module qbio_latch #(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_en,
   input  logic [WIDTH-1:0] byte_data,
   input  logic             bit_en,
   input  logic [1:0]       bit_op,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic             rmw_en,
   input  logic             rmw_valid,
   input  logic [WIDTH-1:0] rmw_result,
   output logic [WIDTH-1:0] latch_q
);
   import qbio_pkg::*;
   logic [WIDTH-1:0] sel;
   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      assign sel[i] = (bit_idx == IDX_W'(i));
   end

   always_comb begin
      nxt = latch_q;
      if (byte_en) begin
         nxt = byte_data;
      end else if (bit_en) begin
         case (bit_op_e'(bit_op))
            BIT_SET: nxt = latch_q | sel;
            BIT_CLR: nxt = latch_q & ~sel;
            BIT_CPY: nxt = bit_val ? (latch_q | sel) : (latch_q & ~sel);
            default: nxt = latch_q;
         endcase
      end else if (rmw_en && rmw_valid) begin
         nxt = rmw_result;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '1;
      else        latch_q <= nxt;
   end

   AST_BYTE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      byte_en |=> latch_q == $past(byte_data)); // R4
   AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_en && bit_en) |=> $countones(latch_q ^ $past(latch_q)) <= 1); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_en && !bit_en && !rmw_en) |=> $stable(latch_q)); // R11
   AST_RMW_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_en && !bit_en && rmw_en && !rmw_valid) |=> $stable(latch_q)); // R5
endmodule

// File: rtl/qbio_pin_sync.sv
module qbio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qbio_pad_ctl.sv
module qbio_pad_ctl #(
   parameter int WIDTH      = 8,
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   assign pad_oe = ~latch_q;

   if (OPEN_DRAIN) begin : g_open_drain
      assign pad_out = '0;
   end else begin : g_pull_up
      assign pad_out = latch_q;
   end
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OPEN_DRAIN  = 1'b0,
   localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_byte_en,
   input  logic [WIDTH-1:0] wr_byte_data,
   input  logic             bit_en,
   input  logic [1:0]       bit_op,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic             rmw_en,
   input  logic [2:0]       rmw_op,
   input  logic [WIDTH-1:0] rmw_operand,
   output logic [WIDTH-1:0] rd_pin_data,
   output logic [WIDTH-1:0] rd_latch_data,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   if (WIDTH < 2) begin : g_bad_width
      $error("qbio_port: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qbio_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] rmw_result;
   logic             rmw_valid;

   qbio_rmw_alu #(.WIDTH(WIDTH)) u_alu (
      .src(latch_q), .operand(rmw_operand), .op(rmw_op),
      .result(rmw_result), .op_valid(rmw_valid));

   qbio_latch #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .byte_en(wr_byte_en), .byte_data(wr_byte_data),
      .bit_en(bit_en), .bit_op(bit_op), .bit_idx(bit_idx), .bit_val(bit_val),
      .rmw_en(rmw_en), .rmw_valid(rmw_valid), .rmw_result(rmw_result),
      .latch_q(latch_q));

   qbio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(rd_pin_data));

   qbio_pad_ctl #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_pad (
      .latch_q(latch_q), .pad_out(pin_out), .pad_oe(pin_oe));

   assign rd_latch_data = latch_q;

   AST_DRIVE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_out) == '0); // R9
   AST_RELEASED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      OPEN_DRAIN ? (pin_out == '0) : ((~pin_oe & ~pin_out) == '0)); // R9
   AST_RMW_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_byte_en && !bit_en && rmw_en && rmw_op == 3'd2)
         |=> rd_latch_data == ($past(rd_latch_data) ^ $past(rmw_operand))); // R6
endmodule

// File: tb/tb_qbio_port.sv
`timescale 1ns/1ps
module tb_qbio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_byte_en = 0, bit_en = 0, bit_val = 0, rmw_en = 0;
   logic [7:0] wr_byte_data = 0, rmw_operand = 0, pin_in = 8'hFF;
   logic [1:0] bit_op = 0;
   logic [2:0] bit_idx = 0, rmw_op = 0;
   logic [7:0] rd_pin_data, rd_latch_data, pin_out, pin_oe;
   logic [7:0] od_rd_pin, od_rd_latch, od_out, od_oe;

   int n_checks = 0;
   int n_fail = 0;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sbq[$];
   logic [7:0] model = 8'hFF;

   always #4 clk = ~clk;

   qbio_port dut (
      .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .bit_en(bit_en), .bit_op(bit_op), .bit_idx(bit_idx), .bit_val(bit_val),
      .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
      .rd_pin_data(rd_pin_data), .rd_latch_data(rd_latch_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

   qbio_port #(.OPEN_DRAIN(1'b1)) dut_od (
      .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
      .bit_en(bit_en), .bit_op(bit_op), .bit_idx(bit_idx), .bit_val(bit_val),
      .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
      .rd_pin_data(od_rd_pin), .rd_latch_data(od_rd_latch),
      .pin_in(pin_in), .pin_out(od_out), .pin_oe(od_oe));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of strobes and pushes the expected latch value
   task automatic drive(string tag, bit be, logic [7:0] bd, bit ben, logic [1:0] bop,
                        logic [2:0] bidx, bit bv, bit re, logic [2:0] rop, logic [7:0] rarg);
      logic [7:0] m;
      @(negedge clk);
      wr_byte_en = be; wr_byte_data = bd;
      bit_en = ben; bit_op = bop; bit_idx = bidx; bit_val = bv;
      rmw_en = re; rmw_op = rop; rmw_operand = rarg;
      m = model;
      if (be) m = bd;
      else if (ben) begin
         case (bop)
            2'd0: m[bidx] = 1'b1;
            2'd1: m[bidx] = 1'b0;
            2'd2: m[bidx] = bv;
            default: ;
         endcase
      end else if (re) begin
         case (rop)
            3'd0: m = model & rarg;
            3'd1: m = model | rarg;
            3'd2: m = model ^ rarg;
            3'd3: m = model + 8'd1;
            3'd4: m = model - 8'd1;
            default: ;
         endcase
      end
      model = m;
      sbq.push_back('{m, tag});
   endtask

   task automatic idle(string tag);
      drive(tag, 0, 8'h00, 0, 2'd0, 3'd0, 0, 0, 3'd0, 8'h00);
   endtask

   // Monitor: pops the expectation after the edge that applies it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            chk(it.tag, rd_latch_data, it.exp);
            chk({it.tag, " oe (R9)"}, pin_oe, ~it.exp);
            chk({it.tag, " out (R9)"}, pin_out, it.exp);
            chk({it.tag, " od out (R9)"}, od_out, 8'h00);
         end
      end
   end

   initial begin
      #(8ns * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 latch", rd_latch_data, 8'hFF);
      chk("R1 oe", pin_oe, 8'h00);
      chk("R1 out", pin_out, 8'hFF);
      chk("R1 rd_pin", rd_pin_data, 8'hFF);
      @(negedge clk);
      rst_n = 1'b1;

      drive("R2 byte 55", 1, 8'h55, 0, 2'd0, 3'd0, 0, 0, 3'd0, 8'h00);
      drive("R10 xor to AA", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd2, 8'hFF);
      drive("R10 xor back 55", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd2, 8'hFF);
      drive("R3 set bit1", 0, 8'h00, 1, 2'd0, 3'd1, 0, 0, 3'd0, 8'h00);
      drive("R3 clr bit0", 0, 8'h00, 1, 2'd1, 3'd0, 0, 0, 3'd0, 8'h00);
      drive("R3 copy bit7", 0, 8'h00, 1, 2'd2, 3'd7, 1, 0, 3'd0, 8'h00);
      drive("R3 nop code", 0, 8'h00, 1, 2'd3, 3'd4, 1, 0, 3'd0, 8'h00);
      idle("R11 hold");
      drive("R4 byte wins", 1, 8'hA5, 1, 2'd0, 3'd1, 0, 1, 3'd1, 8'hFF);
      drive("R4 bit beats rmw", 0, 8'h00, 1, 2'd1, 3'd5, 0, 1, 3'd1, 8'hFF);
      drive("R5 and", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd0, 8'h0F);
      drive("R5 or", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd1, 8'hF0);
      drive("R5 inc", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd3, 8'h00);
      drive("R5 bad code", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd6, 8'hFF);
      drive("R5 load FF", 1, 8'hFF, 0, 2'd0, 3'd0, 0, 0, 3'd0, 8'h00);
      drive("R5 inc wrap", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd3, 8'h00);
      drive("R5 dec wrap", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd4, 8'h00);
      drive("R9 load 3C", 1, 8'h3C, 0, 2'd0, 3'd0, 0, 0, 3'd0, 8'h00);
      idle("R11 hold 3C");
      @(negedge clk);
      chk("R9 od oe", od_oe, 8'hC3);

      // R6 and R8: the pins disagree with the latch
      drive("R6 load 0F", 1, 8'h0F, 0, 2'd0, 3'd0, 0, 0, 3'd0, 8'h00);
      pin_in = 8'hF0;
      drive("R6 or zero from latch", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd1, 8'h00);
      idle("R8 hold");
      drive("R6 xor from latch", 0, 8'h00, 0, 2'd0, 3'd0, 0, 1, 3'd2, 8'h01);
      idle("R11 idle");
      @(negedge clk);
      chk("R8 latch vs pin", rd_latch_data, 8'h0E);
      chk("R7 pin path", rd_pin_data, 8'hF0);

      // R7: two-edge latency
      pin_in = 8'h5A;
      @(posedge clk); #2;
      chk("R7 one edge stale", rd_pin_data, 8'hF0);
      @(posedge clk); #2;
      chk("R7 two edges", rd_pin_data, 8'h5A);
      chk("R8 latch untouched", rd_latch_data, 8'h0E);

      repeat (4) @(posedge clk);
      #2;
      chk("scoreboard drained", 8'(sbq.size()), 8'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule